// File: doc/BRIEF.md
# Delegated Interrupt Selector

This block decides which local interrupt a hart should take next. It takes a vector of pending interrupt lines, a matching vector of per-line enables, and a delegation mask. It also takes the privilege level the hart currently runs at, plus two global enable bits: one for machine mode and one for supervisor mode. From these it produces a valid flag and the index of the one interrupt that wins.

Each line that is both pending and enabled is a candidate. A candidate whose delegation bit is clear belongs to machine level. It survives only if machine level accepts interrupts right now. A candidate whose delegation bit is set belongs to supervisor level. It survives only if supervisor level accepts interrupts right now. The lowest-numbered survivor wins.

The decision is registered once on the rising clock edge, so a trap-entry stage downstream sees a stable, glitch-free choice. The line count is a parameter. The index width follows from it: 6 bits for the default of 64 lines.

Top module: `irqsel_top`

## Requirements
- R1: Only a line whose pending bit and enable bit are both 1 can be selected; a pending line with its enable bit 0 is never reported.
- R2: A line with delegation bit 0 survives when the privilege is supervisor or user (`priv_i` = 1, 0 or 2), or when the privilege is machine (`priv_i` = 3) with `m_gie_i` = 1; in machine mode with `m_gie_i` = 0 no such line survives.
- R3: A line with delegation bit 1 survives when the privilege is user (`priv_i` = 0 or 2), or when the privilege is supervisor (`priv_i` = 1) with `s_gie_i` = 1; it never survives in machine mode or in supervisor mode with `s_gie_i` = 0.
- R4: In the same cycle, delegated and non-delegated candidates are each gated by their own rule (R2, R3), and the survivors of both are merged before the pick.
- R5: Among the survivors, `irq_idx_o` reports the lowest bit position, where bit 0 of each vector is line 0 and bit IRQ_W-1 is the highest line.
- R6: When no line survives, `irq_valid_o` is 0 and `irq_idx_o` is 0.
- R7: Privilege encoding 2 behaves exactly like user mode (encoding 0) for both acceptance rules.
- R8: The outputs reflect the inputs sampled at the previous rising edge (one cycle of latency). A synchronous active-low reset sets `irq_valid_o` to 0 and `irq_idx_o` to 0.
- R9: While all inputs are held unchanged, `irq_valid_o` and `irq_idx_o` do not change from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_pend_i | input | IRQ_W | Pending interrupt lines |
| irq_en_i | input | IRQ_W | Per-line interrupt enables |
| irq_deleg_i | input | IRQ_W | Delegation mask (1 = routed to supervisor level) |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 2 treated as user, 3 machine |
| m_gie_i | input | 1 | Machine-mode global interrupt enable |
| s_gie_i | input | 1 | Supervisor-mode global interrupt enable |
| irq_valid_o | output | 1 | A surviving interrupt exists |
| irq_idx_o | output | $clog2(IRQ_W) | Index of the lowest surviving interrupt |

## Verification
The assertions check several rules on every cycle against the inputs of the previous cycle:
- the index is zero while the valid flag is low;
- a reported line was really pending and enabled;
- machine mode with its global enable off reports nothing;
- supervisor mode with its enable off never reports a delegated line;
- reset clears the output;
- held inputs give an unchanging result.

Some outcomes can only be shown by the bench's scenarios:
- that the lowest-index survivor is the one chosen;
- that delegated and non-delegated candidates mix correctly in one cycle;
- that encoding 2 acts as user mode;
- the exact one-cycle latency.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    // Machine level accepts unless the hart is in machine mode with its enable off.
    function automatic logic mach_accepts(input priv_e lvl, input logic m_gie);
        return (lvl != PRIV_MACH) || m_gie;
    endfunction

    // Supervisor level accepts below supervisor, or in supervisor with its enable on.
    // The reserved encoding is handled as user mode.
    function automatic logic super_accepts(input priv_e lvl, input logic s_gie);
        logic below_s;
        below_s = (lvl == PRIV_USER) || (lvl == PRIV_RSVD);
        return below_s || ((lvl == PRIV_SUPER) && s_gie);
    endfunction

endpackage

// File: rtl/irqsel_accept.sv
module irqsel_accept
    import irqsel_pkg::*;
(
    input  logic [1:0] priv_i,
    input  logic       m_gie_i,
    input  logic       s_gie_i,
    output logic       m_ok_o,
    output logic       s_ok_o
);

    priv_e lvl;

    always_comb begin
        lvl    = priv_e'(priv_i);
        m_ok_o = mach_accepts(lvl, m_gie_i);
        s_ok_o = super_accepts(lvl, s_gie_i);
    end

endmodule

// File: rtl/irqsel_qualify.sv
module irqsel_qualify #(
    parameter int IRQ_W = 64
) (
    input  logic [IRQ_W-1:0] pend_i,
    input  logic [IRQ_W-1:0] en_i,
    input  logic [IRQ_W-1:0] deleg_i,
    input  logic             m_ok_i,
    input  logic             s_ok_i,
    output logic [IRQ_W-1:0] surv_o
);

    // Each line picks its own gate: the supervisor term when delegated,
    // the machine term otherwise.
    for (genvar g = 0; g < IRQ_W; g++) begin : g_line
        logic cand;
        logic gate;
        assign cand      = pend_i[g] & en_i[g];
        assign gate      = deleg_i[g] ? s_ok_i : m_ok_i;
        assign surv_o[g] = cand & gate;
    end

endmodule

// File: rtl/irqsel_lowpick.sv
module irqsel_lowpick #(
    parameter int IRQ_W = 64,
    localparam int IDX_W = $clog2(IRQ_W)
) (
    input  logic [IRQ_W-1:0] vec_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top down, so that the lowest set bit is written last
    // and therefore wins.
    always_comb begin
        any_o = |vec_i;
        idx_o = '0;
        for (int i = IRQ_W - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqsel_top.sv
module irqsel_top
    import irqsel_pkg::*;
#(
    parameter int IRQ_W = 64,
    localparam int IDX_W = $clog2(IRQ_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] irq_pend_i,
    input  logic [IRQ_W-1:0] irq_en_i,
    input  logic [IRQ_W-1:0] irq_deleg_i,
    input  logic [1:0]       priv_i,
    input  logic             m_gie_i,
    input  logic             s_gie_i,
    output logic             irq_valid_o,
    output logic [IDX_W-1:0] irq_idx_o
);

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } sel_t;

    logic             m_ok;
    logic             s_ok;
    logic [IRQ_W-1:0] surv;
    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    sel_t             sel_d;
    sel_t             sel_q;

    irqsel_accept u_accept (
        .priv_i  (priv_i),
        .m_gie_i (m_gie_i),
        .s_gie_i (s_gie_i),
        .m_ok_o  (m_ok),
        .s_ok_o  (s_ok)
    );

    irqsel_qualify #(.IRQ_W(IRQ_W)) u_qualify (
        .pend_i  (irq_pend_i),
        .en_i    (irq_en_i),
        .deleg_i (irq_deleg_i),
        .m_ok_i  (m_ok),
        .s_ok_i  (s_ok),
        .surv_o  (surv)
    );

    irqsel_lowpick #(.IRQ_W(IRQ_W)) u_pick (
        .vec_i (surv),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    always_comb begin
        sel_d       = sel_q;
        sel_d.valid = pick_any;
        sel_d.idx   = pick_any ? pick_idx : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign irq_valid_o = sel_q.valid;
    assign irq_idx_o   = sel_q.idx;

    // R6: an idle output carries index zero
    p_idle_idx_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_valid_o |-> (irq_idx_o == '0));

    // R1: a reported line was pending and enabled at the previous edge
    p_pick_is_candidate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && irq_valid_o) |->
            ((($past(irq_pend_i & irq_en_i) >> irq_idx_o) & IRQ_W'(1)) != '0));

    // R2: machine mode with its enable off reports nothing
    p_mach_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(priv_i) == 2'd3 && !$past(m_gie_i)) |-> !irq_valid_o);

    // R3: supervisor mode with its enable off never reports a delegated line
    p_super_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(priv_i) == 2'd1 && !$past(s_gie_i) && irq_valid_o) |->
            ((($past(irq_deleg_i) >> irq_idx_o) & IRQ_W'(1)) == '0));

    // R8: the first cycle out of reset shows the cleared output
    p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!irq_valid_o && irq_idx_o == '0));

    // R9: held inputs give an unchanging result
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(irq_pend_i) && $stable(irq_en_i) && $stable(irq_deleg_i)
         && $stable(priv_i) && $stable(m_gie_i) && $stable(s_gie_i))
        |=> ($stable(irq_valid_o) && $stable(irq_idx_o)));

endmodule

// File: tb/sim_irqsel_top.sv
module sim_irqsel_top;

    localparam int W  = 64;
    localparam int IW = $clog2(W);

    typedef struct packed {
        logic [W-1:0]  pend;
        logic [W-1:0]  en;
        logic [W-1:0]  deleg;
        logic [1:0]    priv;
        logic          mgie;
        logic          sgie;
        logic          xvalid;
        logic [IW-1:0] xidx;
        logic [7:0]    req;
    } vec_t;

    localparam logic [W-1:0] ALL = {W{1'b1}};
    localparam int NV = 14;

    localparam vec_t TBL [NV] = '{
        '{64'h0, ALL, 64'h0, 2'd0, 1'b1, 1'b1, 1'b0, 6'd0, 8'd6},          // R6 nothing pending
        '{64'h80, 64'h0, 64'h0, 2'd0, 1'b1, 1'b1, 1'b0, 6'd0, 8'd1},       // R1 pending but disabled
        '{64'hA0, 64'h80, 64'h0, 2'd3, 1'b1, 1'b0, 1'b1, 6'd7, 8'd1},      // R1 bit5 disabled, bit7 wins
        '{64'h880, ALL, 64'h0, 2'd3, 1'b0, 1'b1, 1'b0, 6'd0, 8'd2},        // R2 machine, enable off
        '{64'h880, ALL, 64'h0, 2'd1, 1'b0, 1'b0, 1'b1, 6'd7, 8'd2},        // R2 below machine
        '{64'h880, ALL, 64'h80, 2'd3, 1'b1, 1'b1, 1'b1, 6'd11, 8'd4},      // R4 delegated blocked in M
        '{64'h880, ALL, 64'h880, 2'd1, 1'b1, 1'b0, 1'b0, 6'd0, 8'd3},      // R3 super, enable off
        '{64'h880, ALL, 64'h880, 2'd1, 1'b0, 1'b1, 1'b1, 6'd7, 8'd3},      // R3 super, enable on
        '{64'h880, ALL, 64'h880, 2'd0, 1'b0, 1'b0, 1'b1, 6'd7, 8'd3},      // R3 user always accepts
        '{64'h880, ALL, 64'h880, 2'd2, 1'b0, 1'b0, 1'b1, 6'd7, 8'd7},      // R7 encoding 2 as user
        '{64'h8000_0100_0000_0000, ALL, 64'h0, 2'd0, 1'b0, 1'b0, 1'b1, 6'd40, 8'd5}, // R5
        '{ALL, ALL, 64'h0, 2'd0, 1'b0, 1'b0, 1'b1, 6'd0, 8'd5},            // R5 all set, bit0
        '{64'h8000_0000_0000_0000, ALL, 64'h0, 2'd3, 1'b1, 1'b0, 1'b1, 6'd63, 8'd5}, // R5 top line
        '{64'h880, ALL, 64'h80, 2'd1, 1'b0, 1'b0, 1'b1, 6'd11, 8'd4}       // R4 mixed in super
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  pend = '0;
    logic [W-1:0]  en = '0;
    logic [W-1:0]  deleg = '0;
    logic [1:0]    priv = 2'd0;
    logic          mgie = 1'b0;
    logic          sgie = 1'b0;
    logic          valid;
    logic [IW-1:0] idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irqsel_top #(.IRQ_W(W)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_pend_i  (pend),
        .irq_en_i    (en),
        .irq_deleg_i (deleg),
        .priv_i      (priv),
        .m_gie_i     (mgie),
        .s_gie_i     (sgie),
        .irq_valid_o (valid),
        .irq_idx_o   (idx)
    );

    task automatic check(input string tag, input logic ev, input logic [IW-1:0] ei);
        n_chk++;
        if (valid !== ev || idx !== ei) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b idx=%0d, expected valid=%0b idx=%0d",
                     tag, valid, idx, ev, ei);
        end
    endtask

    task automatic apply(input vec_t v);
        pend = v.pend; en = v.en; deleg = v.deleg;
        priv = v.priv; mgie = v.mgie; sgie = v.sgie;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset state", 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            apply(TBL[k]);
            @(negedge clk);
            check($sformatf("R%0d vector %0d", TBL[k].req, k), TBL[k].xvalid, TBL[k].xidx);
        end

        // R8 latency: before the edge the old result remains
        apply(TBL[7]);
        @(negedge clk);
        check("R8 settle", 1'b1, 6'd7);
        apply(TBL[3]);
        #1;
        check("R8 before edge", 1'b1, 6'd7);
        @(negedge clk);
        check("R8 after edge", 1'b0, '0);

        // R9: hold inputs and watch several cycles
        apply(TBL[10]);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            check("R9 hold", 1'b1, 6'd40);
        end

        // R8: synchronous reset clears a live selection
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset while active", 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset release", 1'b1, 6'd40);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule